// File: doc/BRIEF.md
# Parallel Bus Pixel Packer

This block sits behind a parallel write port of the 8080 kind. It turns a stream of bus writes into 18-bit RGB pixel words. The port has a chip select, a write strobe and a data/command line. A write counts on the rising edge of the strobe while the select is low. When the data/command line is high the write carries pixel data. When it is low the write is a command; the packer does not decode it, but it starts a fresh pixel.

Two quasi-static configuration inputs choose the bus width (8, 9, 16 or 18 bits) and the colour depth (65K or 262K). The packer collects one, two or three beats per pixel, depending on that mode. In 65K modes it widens the 5-bit red and blue values to 6 bits. When a pixel is complete it emits a one-clock valid pulse, and the pixel word stays on the output until the next one. All bus inputs pass through a synchroniser into the system clock before edge detection.

Top module: `pixpack_top`

## Requirements
- R1: After reset, `px_valid` is 0 and `px_rgb` is 0.
- R2: Width code 3 (18-bit bus) takes one beat. `px_rgb` equals `bus_d[17:0]` (red 17..12, green 11..6, blue 5..0), and `cfg_deep` has no effect.
- R3: Width code 2 with `cfg_deep`=0 takes one beat: red5 on `bus_d[15:11]`, green6 on `[10:5]` and blue5 on `[4:0]`. Each 5-bit value x becomes the 6-bit value {x, x[4]}.
- R4: Width code 2 with `cfg_deep`=1 takes two beats. Beat 1 supplies red[3:0], green and blue on `bus_d[15:0]`. Beat 2 supplies red[5:4] on `bus_d[15:14]`; its bits 13..0 are ignored.
- R5: Width code 1 (9-bit bus) takes two beats whatever `cfg_deep` is. Beat 1 `bus_d[8:0]` carries red[5:0] and green[5:3]. Beat 2 `bus_d[8:0]` carries green[2:0] and blue[5:0].
- R6: Width code 0 with `cfg_deep`=0 takes two beats on `bus_d[7:0]`. Beat 1 carries red5 then green[5:3]. Beat 2 carries green[2:0] then blue5. Red and blue are widened as in R3.
- R7: Width code 0 with `cfg_deep`=1 takes three beats: red, then green, then blue, each on `bus_d[7:2]`. Bits 1..0 are ignored.
- R8: A strobe rising while `bus_sel_n` is high produces no pixel and does not advance the beat phase.
- R9: A command write (`bus_is_data`=0) produces no pixel and returns the beat phase to the first beat.
- R10: Any change of `cfg_width` or `cfg_deep` returns the beat phase to the first beat.
- R11: `px_valid` is a single-clock pulse. It is high after the (SYNC_STAGES+1)-th rising clock edge that follows the strobe rise. `px_rgb` holds its value until the next pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_is_data | input | 1 | 1 = data write, 0 = command write |
| bus_wstb_n | input | 1 | Write strobe; a write is taken on its rising edge |
| bus_d | input | 18 | Bus data |
| cfg_width | input | 2 | Bus width: 0 = 8, 1 = 9, 2 = 16, 3 = 18 bits |
| cfg_deep | input | 1 | 1 = 262K colour, 0 = 65K colour |
| px_valid | output | 1 | One-clock pulse when a pixel is complete |
| px_rgb | output | 18 | Pixel {red[5:0], green[5:0], blue[5:0]} |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. That makes the strobe-to-valid latency exactly three clocks, so the reference model can predict the clock in which each pixel must appear and flag any pulse at any other time. Every one of the six width/depth combinations is driven with patterns that set the ignored bits, together with interrupted pixels: a deselected write, a command and a mode change each arrive halfway through a pixel.

// File: rtl/pixpack_pkg.sv
package pixpack_pkg;
  localparam int BUS_W = 18;
  localparam int PIX_W = 18;
  localparam int CH_W  = 6;

  typedef enum logic [1:0] {
    BW8  = 2'd0,
    BW9  = 2'd1,
    BW16 = 2'd2,
    BW18 = 2'd3
  } bus_width_e;

  // number of bus beats that form one pixel
  function automatic logic [1:0] beats_for(input bus_width_e w, input logic deep);
    case (w)
      BW18:    beats_for = 2'd1;
      BW9:     beats_for = 2'd2;
      BW16:    beats_for = deep ? 2'd2 : 2'd1;
      default: beats_for = deep ? 2'd3 : 2'd2;
    endcase
  endfunction

  // widen a 5-bit colour value to 6 bits by repeating its top bit below
  function automatic logic [CH_W-1:0] widen5(input logic [4:0] x);
    widen5 = {x, x[4]};
  endfunction
endpackage

// File: rtl/pixpack_sync.sv
module pixpack_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pixpack_strobe.sv
module pixpack_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n_s,
  input  logic is_data_s,
  input  logic wstb_n_s,
  output logic data_evt,
  output logic cmd_evt
);
  logic wstb_prev;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wstb_prev <= 1'b1;
    else        wstb_prev <= wstb_n_s;
  end

  assign rise     = wstb_n_s & ~wstb_prev & ~sel_n_s;
  assign data_evt = rise & is_data_s;
  assign cmd_evt  = rise & ~is_data_s;

  AST_SEL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |-> !(data_evt || cmd_evt)); // R8
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_evt && cmd_evt)); // R9
  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt || cmd_evt) |=> !(data_evt || cmd_evt)); // R11
endmodule

// File: rtl/pixpack_assembler.sv
module pixpack_assembler
  import pixpack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_evt,
  input  logic               cmd_evt,
  input  logic [BUS_W-1:0]   d_s,
  input  bus_width_e         width_i,
  input  logic               deep_i,
  output logic               px_valid_o,
  output logic [PIX_W-1:0]   px_rgb_o
);
  bus_width_e        width_q;
  logic              deep_q;
  logic [1:0]        beat_q;
  logic [15:0]       hold_a;
  logic [CH_W-1:0]   hold_b;
  logic [1:0]        need;
  logic              mode_chg;
  logic              last_beat;
  logic              px_done;
  logic [PIX_W-1:0]  px_next;

  assign need      = beats_for(width_i, deep_i);
  assign mode_chg  = (width_i != width_q) || (deep_i != deep_q);
  assign last_beat = (beat_q == need - 2'd1);
  assign px_done   = data_evt & last_beat & ~mode_chg;

  // pixel built from held beats plus the current beat
  always_comb begin
    case (width_i)
      BW18: px_next = d_s[17:0];
      BW16: px_next = deep_i ? {d_s[15:14], hold_a}
                             : {widen5(d_s[15:11]), d_s[10:5], widen5(d_s[4:0])};
      BW9:  px_next = {hold_a[8:0], d_s[8:0]};
      default: px_next = deep_i ? {hold_a[7:2], hold_b, d_s[7:2]}
                                : {widen5(hold_a[7:3]), hold_a[2:0], d_s[7:5], widen5(d_s[4:0])};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= BW8;
      deep_q  <= 1'b0;
    end else begin
      width_q <= width_i;
      deep_q  <= deep_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= 2'd0;
      hold_a <= '0;
      hold_b <= '0;
    end else if (cmd_evt || mode_chg) begin
      beat_q <= 2'd0;
    end else if (data_evt) begin
      beat_q <= last_beat ? 2'd0 : beat_q + 2'd1;
      if (beat_q == 2'd0) hold_a <= d_s[15:0];
      if (beat_q == 2'd1) hold_b <= d_s[7:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_valid_o <= 1'b0;
      px_rgb_o   <= '0;
    end else begin
      px_valid_o <= px_done;
      if (px_done) px_rgb_o <= px_next;
    end
  end

  AST_CMD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |=> beat_q == 2'd0); // R9
  AST_MODE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> beat_q == 2'd0); // R10
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> beat_q < need); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid_o |=> !px_valid_o); // R11
  AST_VALID_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid_o |-> $past(data_evt)); // R11
  AST_RGB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !px_valid_o |-> $stable(px_rgb_o) || $past(px_done)); // R11
  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && !mode_chg && width_i == BW18) |=> px_valid_o); // R2
endmodule

// File: rtl/pixpack_top.sv
module pixpack_top
  import pixpack_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_is_data,
  input  logic              bus_wstb_n,
  input  logic [BUS_W-1:0]  bus_d,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_deep,
  output logic              px_valid,
  output logic [PIX_W-1:0]  px_rgb
);
  localparam int SW = BUS_W + 3;
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {BUS_W{1'b0}}};

  logic [SW-1:0]    raw_bus;
  logic [SW-1:0]    syn_bus;
  logic             sel_n_s, is_data_s, wstb_n_s;
  logic [BUS_W-1:0] d_s;
  logic             data_evt, cmd_evt;

  assign raw_bus = {bus_sel_n, bus_is_data, bus_wstb_n, bus_d};

  pixpack_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_bus), .q_o(syn_bus)
  );

  assign {sel_n_s, is_data_s, wstb_n_s, d_s} = syn_bus;

  pixpack_strobe u_strobe (
    .clk(clk), .rst_n(rst_n),
    .sel_n_s(sel_n_s), .is_data_s(is_data_s), .wstb_n_s(wstb_n_s),
    .data_evt(data_evt), .cmd_evt(cmd_evt)
  );

  pixpack_assembler u_asm (
    .clk(clk), .rst_n(rst_n),
    .data_evt(data_evt), .cmd_evt(cmd_evt), .d_s(d_s),
    .width_i(bus_width_e'(cfg_width)), .deep_i(cfg_deep),
    .px_valid_o(px_valid), .px_rgb_o(px_rgb)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !px_valid); // R1
endmodule

// File: tb/pixpack_top_tb_top.sv
module pixpack_top_tb_top;
  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_n = 1'b1, bus_is_data = 1'b1, bus_wstb_n = 1'b1;
  logic [17:0] bus_d = '0;
  logic [1:0]  cfg_width = 2'd3;
  logic        cfg_deep = 1'b1;
  logic        px_valid;
  logic [17:0] px_rgb;

  int tests = 0, fails = 0, cyc = 0;
  bit started = 0;
  int m_width = 18;
  bit m_deep = 1;
  int beats[$];
  int exp_pix[$];
  int exp_cyc[$];
  string exp_tag[$];
  int last_pix = 0;

  always #2ns clk = ~clk;
  always @(posedge clk) cyc++;

  pixpack_top #(.SYNC_STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_is_data(bus_is_data),
    .bus_wstb_n(bus_wstb_n), .bus_d(bus_d), .cfg_width(cfg_width), .cfg_deep(cfg_deep),
    .px_valid(px_valid), .px_rgb(px_rgb)
  );

  function automatic int wid(int v5);
    return v5 * 2 + v5 / 16;
  endfunction

  // reference pixel from collected beats, arithmetic only
  function automatic int compose();
    int r, g, b;
    int d0 = beats[0];
    int d1 = (beats.size() > 1) ? beats[1] : 0;
    int d2 = (beats.size() > 2) ? beats[2] : 0;
    if (m_width == 18) begin
      r = (d0 / 4096) % 64; g = (d0 / 64) % 64; b = d0 % 64;
    end else if (m_width == 16 && !m_deep) begin
      r = wid((d0 / 2048) % 32); g = (d0 / 32) % 64; b = wid(d0 % 32);
    end else if (m_width == 16) begin
      r = ((d1 / 16384) % 4) * 16 + (d0 / 4096) % 16; g = (d0 / 64) % 64; b = d0 % 64;
    end else if (m_width == 9) begin
      r = (d0 / 8) % 64; g = (d0 % 8) * 8 + (d1 / 64) % 8; b = d1 % 64;
    end else if (!m_deep) begin
      r = wid((d0 / 8) % 32); g = (d0 % 8) * 8 + (d1 / 32) % 8; b = wid(d1 % 32);
    end else begin
      r = (d0 / 4) % 64; g = (d1 / 4) % 64; b = (d2 / 4) % 64;
    end
    return r * 4096 + g * 64 + b;
  endfunction

  function automatic int need();
    if (m_width == 18) return 1;
    if (m_width == 16) return m_deep ? 2 : 1;
    if (m_width == 9) return 2;
    return m_deep ? 3 : 2;
  endfunction

  task automatic set_mode(input int w, input bit deep);
    @(negedge clk);
    m_width = w; m_deep = deep; beats.delete();
    cfg_width = (w == 8) ? 2'd0 : (w == 9) ? 2'd1 : (w == 16) ? 2'd2 : 2'd3;
    cfg_deep = deep;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input bit is_data, input int d, input bit sel, input string tag);
    @(negedge clk);
    bus_sel_n = !sel; bus_is_data = is_data; bus_d = d[17:0]; bus_wstb_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_wstb_n = 1'b1;
    if (sel) begin
      if (!is_data) beats.delete();
      else begin
        beats.push_back(d);
        if (beats.size() == need()) begin
          exp_pix.push_back(compose());
          exp_cyc.push_back(cyc + LAT);
          exp_tag.push_back(tag);
          beats.delete();
        end
      end
    end
    repeat (4) @(negedge clk);
    bus_sel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        tests++;
        if (px_valid !== 1'b1 || px_rgb !== exp_pix[0][17:0]) begin
          fails++;
          $display("FAIL %s/R11: valid=%0b rgb=%05h expected valid=1 rgb=%05h",
                   exp_tag[0], px_valid, px_rgb, exp_pix[0][17:0]);
        end
        last_pix = exp_pix[0];
        void'(exp_pix.pop_front()); void'(exp_cyc.pop_front()); void'(exp_tag.pop_front());
      end else if (px_valid !== 1'b0) begin
        tests++; fails++;
        $display("FAIL R8/R9/R11: unexpected valid=%0b rgb=%05h expected valid=0", px_valid, px_rgb);
      end
    end
  end

  initial begin
    #800us;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (px_valid !== 1'b0 || px_rgb !== 18'd0) begin
      fails++;
      $display("FAIL R1: valid=%0b rgb=%05h expected valid=0 rgb=00000", px_valid, px_rgb);
    end
    started = 1;

    set_mode(18, 1);
    bus_wr(1, 'h3FFFF, 1, "R2");
    bus_wr(1, 'h2A5C3, 1, "R2");
    set_mode(18, 0);
    bus_wr(1, 'h00001, 1, "R2");

    set_mode(16, 0);
    bus_wr(1, 'h3F81F, 1, "R3");
    bus_wr(1, 'h07BEF, 1, "R3");
    bus_wr(1, 'h08410, 1, "R3");

    set_mode(16, 1);
    bus_wr(1, 'h0A5C3, 1, "R4");
    bus_wr(1, 'h0BFFF, 1, "R4");
    bus_wr(1, 'h01234, 1, "R4");
    bus_wr(1, 'h04ABC, 1, "R4");

    set_mode(9, 0);
    bus_wr(1, 'h3FFFF, 1, "R5");
    bus_wr(1, 'h000AA, 1, "R5");
    set_mode(9, 1);
    bus_wr(1, 'h00155, 1, "R5");
    bus_wr(1, 'h3FFC3, 1, "R5");

    set_mode(8, 0);
    bus_wr(1, 'h3FFF8, 1, "R6");
    bus_wr(1, 'h0001F, 1, "R6");
    bus_wr(1, 'h0005A, 1, "R6");
    bus_wr(1, 'h2AAC3, 1, "R6");

    set_mode(8, 1);
    bus_wr(1, 'h000FD, 1, "R7");
    bus_wr(1, 'h3FF02, 1, "R7");
    bus_wr(1, 'h000AB, 1, "R7");

    // deselected write halfway through a pixel
    bus_wr(1, 'h000FC, 1, "R8");
    bus_wr(1, 'h00000, 0, "R8");
    bus_wr(1, 'h00080, 1, "R8");
    bus_wr(1, 'h00040, 1, "R8");

    // command halfway through a pixel
    bus_wr(1, 'h000FC, 1, "R9");
    bus_wr(0, 'h0002C, 1, "R9");
    bus_wr(1, 'h00014, 1, "R9");
    bus_wr(1, 'h00028, 1, "R9");
    bus_wr(1, 'h0003C, 1, "R9");

    // mode change halfway through a pixel
    set_mode(16, 1);
    bus_wr(1, 'h01111, 1, "R10");
    set_mode(18, 1);
    bus_wr(1, 'h12345, 1, "R10");

    repeat (10) @(negedge clk);
    tests++;
    if (px_rgb !== last_pix[17:0] || exp_cyc.size() != 0) begin
      fails++;
      $display("FAIL R11: rgb=%05h pending=%0d expected rgb=%05h pending=0",
               px_rgb, exp_cyc.size(), last_pix[17:0]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule